// File: doc/BRIEF.md
# Vector Extension Prefix Decoder

This block sits behind an instruction pre-decoder and interprets the compact vector-extension prefix that may open an instruction. Bytes arrive one at a time on a valid/ready handshake. Along with them come the processor operating mode and a vector of flags for the legacy prefixes already consumed ahead of this point. The block recognises the two-byte form (lead byte C5h) and the three-byte form (lead byte C4h). It expands the inverted and packed payload into plain fields: register-extension bits, operand width bit, the true index of the extra source register, vector length, the implied SIMD prefix and the opcode map. It then accepts the opcode byte and reports everything in a one-cycle result pulse.

A small per-opcode legality side input is sampled with the opcode byte. It says whether the opcode reads the extra register field and which vector lengths it permits. The block folds all prefix-level illegal encodings into a single undefined-opcode fault flag. A separate immediate port turns an imm8 byte into the fourth register index used by four-operand forms. Any byte that does not start a vector prefix is passed through as a legacy opcode.

Top module: `vxp_decoder`

## Requirements
- R1: In 32-bit or 64-bit mode, a lead byte C5h selects the short form (res_form=1) and C4h selects the long form (res_form=2). Any other lead byte is reported as legacy (res_form=0) with res_opcode equal to that byte, no fault, and all field outputs zero.
- R2: Short form payload byte: bit 7 is inverted R, bits 6:3 are inverted vvvv, bit 2 is L, bits 1:0 are pp. Long form first payload byte: bit 7 is inverted R, bit 6 is inverted X, bit 5 is inverted B, bits 4:0 are the map select. Long form second payload byte: bit 7 is W, bits 6:3 are inverted vvvv, bit 2 is L, bits 1:0 are pp. The short form reports X=0, B=0, W=0 and map code 1.
- R3: res_vreg is the ones' complement of the stored vvvv field, which is the true register index.
- R4: res_simd carries pp (0 none, 1 66h, 2 F3h, 3 F2h). A long-form map select of 1, 2 or 3 is reported on res_map as 1 (0Fh), 2 (0F38h) or 3 (0F3Ah). Any other map select raises res_fault.
- R5: If any flag of leg_seen (bit 0 LOCK, bit 1 66h, bit 2 F3h, bit 3 F2h, bit 4 REX) is set when a vector lead byte is accepted, res_fault is raised.
- R6: When op_uses_vvvv is 0 and the decoded register index is not 0, res_fault is raised.
- R7: L=0 means 128-bit and L=1 means 256-bit. When op_len_any is 0 and op_len_allow bit L is 0 (bit 0 for 128, bit 1 for 256), res_fault is raised.
- R8: In real mode (cpu_mode=0) and virtual-8086 mode (cpu_mode=1), C4h and C5h are reported as legacy opcodes.
- R9: In 32-bit mode (cpu_mode=2), when the byte after C4h/C5h has bits 7:6 not equal to 11b, that byte is not accepted (in_ready stays 0). The result is then legacy, with res_opcode equal to the lead byte.
- R10: In 32-bit mode, the top bit of the register index is forced to 0 and the B bit reads 0.
- R11: imm_valid with imm_byte gives is4_valid one cycle later, with is4_reg=imm_byte[7:4]. In 32-bit mode bit 3 of is4_reg is 0, and imm_byte[3:0] has no effect.
- R12: After reset, in_ready=1, res_valid=0 and is4_valid=0. res_valid is high for exactly one cycle, the cycle after the last instruction byte is accepted, and in_ready is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction byte valid |
| in_ready | output | 1 | Byte accepted this cycle when high with in_valid |
| in_byte | input | 8 | Instruction byte |
| cpu_mode | input | 2 | 0 real, 1 virtual-8086, 2 32-bit, 3 64-bit |
| leg_seen | input | 5 | Legacy prefixes seen: LOCK, 66h, F3h, F2h, REX |
| op_uses_vvvv | input | 1 | Opcode reads the extra register field |
| op_len_any | input | 1 | Opcode ignores L |
| op_len_allow | input | 2 | Permitted lengths, bit 0 128-bit, bit 1 256-bit |
| imm_valid | input | 1 | Immediate byte valid for register extraction |
| imm_byte | input | 8 | Immediate byte |
| res_valid | output | 1 | Result pulse |
| res_form | output | 2 | 0 legacy, 1 short, 2 long |
| res_opcode | output | 8 | Opcode byte |
| res_vreg | output | 4 | Extra source register index |
| res_l | output | 1 | Vector length bit |
| res_w | output | 1 | Width bit |
| res_r | output | 1 | ModRM.reg extension |
| res_x | output | 1 | SIB.index extension |
| res_b | output | 1 | Base/rm extension |
| res_simd | output | 2 | Implied SIMD prefix code |
| res_map | output | 2 | Opcode map code |
| res_fault | output | 1 | Undefined-opcode fault |
| is4_valid | output | 1 | Fourth register valid |
| is4_reg | output | 4 | Fourth register index |

## Verification
Two checks can fail the same instruction in the same result cycle: the unused-register rule and the vector-length rule both look at the side inputs sampled with the opcode byte. The 32-bit register masking also meets the unused-register rule, since a raw field of 0111b gives index 8 in 64-bit mode, which faults, but index 0 in 32-bit mode, which does not. The bench sends the same payload bytes under both modes and under several side-input settings. It then compares the single fault flag against a value worked out from each rule alone.

// File: rtl/vxp_pkg.sv
// Shared types and constants for the vector prefix decoder.
// Assumes 8-bit instruction bytes and a 4-bit register index.
package vxp_pkg;
    localparam int BYTE_W = 8;
    localparam int VREG_W = 4;
    localparam int LEG_W  = 5;

    localparam logic [BYTE_W-1:0] LEAD_SHORT = 8'hC5;
    localparam logic [BYTE_W-1:0] LEAD_LONG  = 8'hC4;

    typedef enum logic [1:0] {
        CPU_REAL   = 2'd0,
        CPU_V86    = 2'd1,
        CPU_PROT32 = 2'd2,
        CPU_LONG64 = 2'd3
    } cpu_mode_e;

    typedef enum logic [1:0] {
        FORM_LEGACY = 2'd0,
        FORM_SHORT  = 2'd1,
        FORM_LONG   = 2'd2
    } pfx_form_e;

    typedef struct packed {
        logic              r;
        logic              x;
        logic              b;
        logic              w;
        logic              l;
        logic [VREG_W-1:0] vreg;
        logic [1:0]        simd;
        logic [1:0]        map;
        logic              map_bad;
    } vfields_t;
endpackage

// File: rtl/vxp_unpack.sv
// Expands the inverted, packed payload bytes into plain fields.
// Assumes pay1/pay2 hold the payload in arrival order; pay2 is unused for
// the short form. narrow selects 32-bit rules (top register bit and B dropped).
module vxp_unpack
    import vxp_pkg::*;
(
    input  pfx_form_e          form,
    input  logic [BYTE_W-1:0]  pay1,
    input  logic [BYTE_W-1:0]  pay2,
    input  logic               narrow,
    output vfields_t           f
);
    logic [VREG_W-1:0] vraw;

    // Field extraction per prefix form.
    always_comb begin
        f    = '0;
        vraw = '0;
        if (form == FORM_SHORT) begin
            f.r    = ~pay1[7];
            vraw   = ~pay1[6:3];
            f.l    = pay1[2];
            f.simd = pay1[1:0];
            f.map  = 2'd1;
        end else if (form == FORM_LONG) begin
            f.r       = ~pay1[7];
            f.x       = ~pay1[6];
            f.b       = narrow ? 1'b0 : ~pay1[5];
            f.map     = pay1[1:0];
            f.map_bad = !((pay1[4:0] == 5'd1) || (pay1[4:0] == 5'd2) ||
                          (pay1[4:0] == 5'd3));
            f.w       = pay2[7];
            vraw      = ~pay2[6:3];
            f.l       = pay2[2];
            f.simd    = pay2[1:0];
        end
        f.vreg = narrow ? {1'b0, vraw[VREG_W-2:0]} : vraw;
    end
endmodule

// File: rtl/vxp_fault_check.sv
// Folds the prefix-level illegal encodings into one fault flag.
// Assumes the side inputs belong to the opcode that follows the prefix.
module vxp_fault_check #(
    parameter int VREG_W = 4
) (
    input  logic              is_vec,
    input  logic              leg_any,
    input  logic              map_bad,
    input  logic              uses_vvvv,
    input  logic [VREG_W-1:0] vreg,
    input  logic              len_any,
    input  logic [1:0]        len_allow,
    input  logic              l,
    output logic              fault
);
    logic reg_bad;
    logic len_bad;

    // Individual rule violations and their union.
    always_comb begin
        reg_bad = !uses_vvvv && (vreg != '0);
        len_bad = !len_any && !len_allow[l];
        fault   = is_vec && (leg_any || map_bad || reg_bad || len_bad);
    end
endmodule

// File: rtl/vxp_is4.sv
// Extracts the fourth register index from an imm8 byte, one cycle latency.
// Assumes narrow is 1 in 32-bit mode, where the top index bit is dropped.
module vxp_is4 #(
    parameter int IMM_W = 8,
    parameter int REG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             imm_valid,
    input  logic [IMM_W-1:0] imm_byte,
    input  logic             narrow,
    output logic             is4_valid,
    output logic [REG_W-1:0] is4_reg
);
    localparam int TOP = IMM_W - 1;

    // Register the upper imm8 field, masking the top bit in 32-bit mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is4_valid <= 1'b0;
            is4_reg   <= '0;
        end else begin
            is4_valid <= imm_valid;
            if (imm_valid)
                is4_reg <= {imm_byte[TOP] & ~narrow, imm_byte[TOP-1:IMM_W-REG_W]};
        end
    end

    a_r11_narrow_mask: assert property (@(posedge clk) disable iff (!rst_n)
        imm_valid && narrow |=> is4_valid && !is4_reg[REG_W-1]);
endmodule

// File: rtl/vxp_decoder.sv
// Top: byte-serial vector prefix decoder with a one-cycle result pulse.
// Assumes the upstream holds in_valid/in_byte stable until accepted and
// presents the legality side inputs together with the opcode byte.
module vxp_decoder
    import vxp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_byte,
    input  logic [1:0]  cpu_mode,
    input  logic [4:0]  leg_seen,
    input  logic        op_uses_vvvv,
    input  logic        op_len_any,
    input  logic [1:0]  op_len_allow,
    input  logic        imm_valid,
    input  logic [7:0]  imm_byte,
    output logic        res_valid,
    output logic [1:0]  res_form,
    output logic [7:0]  res_opcode,
    output logic [3:0]  res_vreg,
    output logic        res_l,
    output logic        res_w,
    output logic        res_r,
    output logic        res_x,
    output logic        res_b,
    output logic [1:0]  res_simd,
    output logic [1:0]  res_map,
    output logic        res_fault,
    output logic        is4_valid,
    output logic [3:0]  is4_reg
);
    typedef enum logic [2:0] {S_LEAD, S_PAY1, S_PAY2, S_OPC, S_DONE} st_e;

    st_e               st;
    pfx_form_e         form_q;
    cpu_mode_e         mode_q;
    logic [BYTE_W-1:0] lead_q, pay1_q, pay2_q, opc_q;
    logic              leg_q, uses_q, any_q;
    logic [1:0]        allow_q;
    logic              recog, peek_legacy, take, is_vec, fault;
    vfields_t          f;

    // Handshake and recognition decisions for the current byte.
    always_comb begin
        recog       = (cpu_mode_e'(cpu_mode) == CPU_PROT32) ||
                      (cpu_mode_e'(cpu_mode) == CPU_LONG64);
        peek_legacy = (st == S_PAY1) && (mode_q == CPU_PROT32) &&
                      in_valid && (in_byte[7:6] != 2'b11);
        in_ready    = (st != S_DONE) && !peek_legacy;
        take        = in_valid && in_ready;
        is_vec      = (form_q != FORM_LEGACY);
    end

    // Byte sequencer: lead, payload, opcode, result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_LEAD;
            form_q  <= FORM_LEGACY;
            mode_q  <= CPU_REAL;
            lead_q  <= '0;
            pay1_q  <= '0;
            pay2_q  <= '0;
            opc_q   <= '0;
            leg_q   <= 1'b0;
            uses_q  <= 1'b0;
            any_q   <= 1'b0;
            allow_q <= '0;
        end else begin
            case (st)
                S_LEAD: if (take) begin
                    lead_q <= in_byte;
                    mode_q <= cpu_mode_e'(cpu_mode);
                    leg_q  <= |leg_seen;
                    if (recog && (in_byte == LEAD_SHORT || in_byte == LEAD_LONG)) begin
                        form_q <= (in_byte == LEAD_SHORT) ? FORM_SHORT : FORM_LONG;
                        st     <= S_PAY1;
                    end else begin
                        form_q <= FORM_LEGACY;
                        opc_q  <= in_byte;
                        st     <= S_DONE;
                    end
                end
                S_PAY1: if (peek_legacy) begin
                    form_q <= FORM_LEGACY;
                    opc_q  <= lead_q;
                    st     <= S_DONE;
                end else if (take) begin
                    pay1_q <= in_byte;
                    st     <= (form_q == FORM_SHORT) ? S_OPC : S_PAY2;
                end
                S_PAY2: if (take) begin
                    pay2_q <= in_byte;
                    st     <= S_OPC;
                end
                S_OPC: if (take) begin
                    opc_q   <= in_byte;
                    uses_q  <= op_uses_vvvv;
                    any_q   <= op_len_any;
                    allow_q <= op_len_allow;
                    st      <= S_DONE;
                end
                default: st <= S_LEAD;
            endcase
        end
    end

    vxp_unpack u_unpack (
        .form   (form_q),
        .pay1   (pay1_q),
        .pay2   (pay2_q),
        .narrow (mode_q == CPU_PROT32),
        .f      (f)
    );

    vxp_fault_check #(.VREG_W(VREG_W)) u_fault (
        .is_vec    (is_vec),
        .leg_any   (leg_q),
        .map_bad   (f.map_bad),
        .uses_vvvv (uses_q),
        .vreg      (f.vreg),
        .len_any   (any_q),
        .len_allow (allow_q),
        .l         (f.l),
        .fault     (fault)
    );

    vxp_is4 #(.IMM_W(BYTE_W), .REG_W(VREG_W)) u_is4 (
        .clk       (clk),
        .rst_n     (rst_n),
        .imm_valid (imm_valid),
        .imm_byte  (imm_byte),
        .narrow    (cpu_mode_e'(cpu_mode) == CPU_PROT32),
        .is4_valid (is4_valid),
        .is4_reg   (is4_reg)
    );

    // Result outputs; legacy results carry no prefix fields.
    always_comb begin
        res_valid  = (st == S_DONE);
        res_form   = form_q;
        res_opcode = opc_q;
        res_vreg   = is_vec ? f.vreg : '0;
        res_l      = is_vec & f.l;
        res_w      = is_vec & f.w;
        res_r      = is_vec & f.r;
        res_x      = is_vec & f.x;
        res_b      = is_vec & f.b;
        res_simd   = is_vec ? f.simd : '0;
        res_map    = is_vec ? f.map : '0;
        res_fault  = fault;
    end

    a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    a_r1_legacy_clean: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_form == 2'd0 |-> !res_fault && res_vreg == 4'd0);
    a_r10_narrow_fields: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_form != 2'd0 && mode_q == CPU_PROT32 |->
        !res_vreg[3] && !res_b && !res_r && !res_x);
    a_r4_good_map: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_form != 2'd0 && !res_fault |-> res_map != 2'd0);
endmodule

// File: tb/vxp_decoder_test.sv
`timescale 1ns/1ps
module vxp_decoder_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [7:0] in_byte = 8'h00;
    logic [1:0] cpu_mode = 2'd3;
    logic [4:0] leg_seen = 5'd0;
    logic op_uses_vvvv = 1'b1;
    logic op_len_any = 1'b0;
    logic [1:0] op_len_allow = 2'b11;
    logic imm_valid = 1'b0;
    logic [7:0] imm_byte = 8'h00;
    logic res_valid, res_l, res_w, res_r, res_x, res_b, res_fault, is4_valid;
    logic [1:0] res_form, res_simd, res_map;
    logic [7:0] res_opcode;
    logic [3:0] res_vreg, is4_reg;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    vxp_decoder uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    // Sends n bytes, then samples the result cycle.
    task automatic run(input int n, input logic [7:0] b0, b1, b2, b3);
        put(b0);
        if (n > 1) put(b1);
        if (n > 2) put(b2);
        if (n > 3) put(b3);
        @(negedge clk);
        chk("R12 result pulse", res_valid, 1);
        chk("R12 ready low in result cycle", in_ready, 0);
    endtask

    task automatic exp_fields(input string tag, input logic [1:0] form, input logic [3:0] vreg,
                              input logic l, w, r, x, b, input logic [1:0] simd, map,
                              input logic fault, input logic [7:0] opc);
        chk({tag, " form"}, res_form, form);
        chk({tag, " vreg"}, res_vreg, vreg);
        chk({tag, " L"}, res_l, l);
        chk({tag, " W"}, res_w, w);
        chk({tag, " R"}, res_r, r);
        chk({tag, " X"}, res_x, x);
        chk({tag, " B"}, res_b, b);
        chk({tag, " simd"}, res_simd, simd);
        chk({tag, " map"}, res_map, map);
        chk({tag, " fault"}, res_fault, fault);
        chk({tag, " opcode"}, res_opcode, opc);
    endtask

    task automatic t_reset;
        chk("R12 reset ready", in_ready, 1);
        chk("R12 reset res_valid", res_valid, 0);
        chk("R12 reset is4_valid", is4_valid, 0);
    endtask

    task automatic t_short_form;
        cpu_mode = 2'd3; op_uses_vvvv = 1; op_len_allow = 2'b11;
        run(3, 8'hC5, 8'h56, 8'h58, 8'h00);
        exp_fields("R1 R2 R3 R4 short", 2'd1, 4'd5, 1, 0, 1, 0, 0, 2'd2, 2'd1, 0, 8'h58);
    endtask

    task automatic t_long_form;
        cpu_mode = 2'd3; op_uses_vvvv = 1; op_len_allow = 2'b11;
        run(4, 8'hC4, 8'h82, 8'h99, 8'h2A);
        exp_fields("R2 R3 R4 long map2", 2'd2, 4'd12, 0, 1, 0, 1, 1, 2'd1, 2'd2, 0, 8'h2A);
        op_uses_vvvv = 0;
        run(4, 8'hC4, 8'hE3, 8'h7C, 8'h0F);
        exp_fields("R4 long map3", 2'd2, 4'd0, 1, 0, 0, 0, 0, 2'd0, 2'd3, 0, 8'h0F);
    endtask

    task automatic t_bad_map;
        cpu_mode = 2'd3; op_uses_vvvv = 0; op_len_allow = 2'b11;
        run(4, 8'hC4, 8'hE0, 8'h7C, 8'h10);
        chk("R4 map select 0 faults", res_fault, 1);
        run(4, 8'hC4, 8'hE4, 8'h7C, 8'h10);
        chk("R4 map select 4 faults", res_fault, 1);
    endtask

    task automatic t_leg_prefix;
        cpu_mode = 2'd3; op_uses_vvvv = 0; op_len_allow = 2'b11;
        leg_seen = 5'b00000;
        run(3, 8'hC5, 8'hF8, 8'h77, 8'h00);
        chk("R5 no prefix no fault", res_fault, 0);
        leg_seen = 5'b00010;
        run(3, 8'hC5, 8'hF8, 8'h77, 8'h00);
        chk("R5 66h before prefix", res_fault, 1);
        leg_seen = 5'b10000;
        run(3, 8'hC5, 8'hF8, 8'h77, 8'h00);
        chk("R5 REX before prefix", res_fault, 1);
        leg_seen = 5'b00001;
        run(3, 8'hC5, 8'hF8, 8'h77, 8'h00);
        chk("R5 LOCK before prefix", res_fault, 1);
        leg_seen = 5'b00000;
    endtask

    task automatic t_unused_vvvv;
        cpu_mode = 2'd3; op_len_allow = 2'b11;
        op_uses_vvvv = 0;
        run(3, 8'hC5, 8'hF0, 8'h51, 8'h00);
        chk("R6 unused register nonzero", res_fault, 1);
        op_uses_vvvv = 1;
        run(3, 8'hC5, 8'hF0, 8'h51, 8'h00);
        chk("R6 used register ok", res_fault, 0);
        chk("R3 register 1", res_vreg, 1);
    endtask

    task automatic t_length;
        cpu_mode = 2'd3; op_uses_vvvv = 0;
        op_len_any = 0; op_len_allow = 2'b01;
        run(3, 8'hC5, 8'hFC, 8'h60, 8'h00);
        chk("R7 256 when only 128", res_fault, 1);
        op_len_any = 1;
        run(3, 8'hC5, 8'hFC, 8'h60, 8'h00);
        chk("R7 length ignored", res_fault, 0);
        op_len_any = 0; op_len_allow = 2'b10;
        run(3, 8'hC5, 8'hFC, 8'h60, 8'h00);
        chk("R7 256 allowed", res_fault, 0);
        run(3, 8'hC5, 8'hF8, 8'h60, 8'h00);
        chk("R7 128 when only 256", res_fault, 1);
        op_len_allow = 2'b11;
        // Both rules broken in one instruction
        op_len_allow = 2'b01;
        run(3, 8'hC5, 8'hF4, 8'h60, 8'h00);
        chk("R6 R7 both rules", res_fault, 1);
        op_len_allow = 2'b11;
    endtask

    task automatic t_modes;
        cpu_mode = 2'd0;
        run(1, 8'hC5, 8'h00, 8'h00, 8'h00);
        exp_fields("R8 real mode", 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'hC5);
        cpu_mode = 2'd1;
        run(1, 8'hC4, 8'h00, 8'h00, 8'h00);
        exp_fields("R8 v86 mode", 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'hC4);
        cpu_mode = 2'd3;
        run(1, 8'h90, 8'h00, 8'h00, 8'h00);
        exp_fields("R1 legacy byte", 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h90);
    endtask

    task automatic t_peek32;
        cpu_mode = 2'd2;
        put(8'hC4);
        @(negedge clk);
        in_valid = 1'b1; in_byte = 8'h45;
        #1 chk("R9 next byte not taken", in_ready, 0);
        @(negedge clk);
        chk("R9 result pulse", res_valid, 1);
        chk("R9 legacy form", res_form, 0);
        chk("R9 lead as opcode", res_opcode, 8'hC4);
        in_valid = 1'b0;
        put(8'hC5);
        @(negedge clk);
        in_valid = 1'b1; in_byte = 8'h3F;
        #1 chk("R9 short lead stall", in_ready, 0);
        @(negedge clk);
        chk("R9 short lead legacy", res_form, 0);
        chk("R9 short lead opcode", res_opcode, 8'hC5);
        in_valid = 1'b0;
    endtask

    task automatic t_narrow;
        op_uses_vvvv = 1; op_len_allow = 2'b11;
        cpu_mode = 2'd2;
        run(4, 8'hC4, 8'hC1, 8'h10, 8'h33);
        exp_fields("R10 32-bit", 2'd2, 4'd5, 0, 0, 0, 0, 0, 0, 2'd1, 0, 8'h33);
        cpu_mode = 2'd3;
        run(4, 8'hC4, 8'hC1, 8'h10, 8'h33);
        exp_fields("R10 64-bit same bytes", 2'd2, 4'd13, 0, 0, 0, 0, 1, 0, 2'd1, 0, 8'h33);
        op_uses_vvvv = 0;
        cpu_mode = 2'd2;
        run(4, 8'hC4, 8'hC1, 8'h38, 8'h33);
        chk("R10 R6 top bit ignored", res_fault, 0);
        cpu_mode = 2'd3;
        run(4, 8'hC4, 8'hC1, 8'h38, 8'h33);
        chk("R6 index 8 unused", res_fault, 1);
        chk("R3 index 8", res_vreg, 8);
    endtask

    task automatic t_is4;
        cpu_mode = 2'd3;
        @(negedge clk);
        imm_valid = 1; imm_byte = 8'hA7;
        @(negedge clk);
        imm_valid = 0;
        chk("R11 valid", is4_valid, 1);
        chk("R11 64-bit reg", is4_reg, 4'hA);
        cpu_mode = 2'd2;
        imm_valid = 1; imm_byte = 8'hA0;
        @(negedge clk);
        imm_valid = 0;
        chk("R11 32-bit reg", is4_reg, 4'h2);
        @(negedge clk);
        chk("R11 valid drops", is4_valid, 0);
        cpu_mode = 2'd3;
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short_form();
        t_long_form();
        t_bad_map();
        t_leg_prefix();
        t_unused_vvvv();
        t_length();
        t_modes();
        t_peek32();
        t_narrow();
        t_is4();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule